// File: doc/BRIEF.md
# Cascadable Configuration Memory Readout Controller

This block is the read side of a configuration memory that streams a stored bitstream into an FPGA, one bit per clock on lane 0 or one byte per clock on all eight lanes. The image sits in a small synthesizable ROM whose contents are computed from the address. The memory is split into equal revision banks. A chip-enable, an output-enable that doubles as a counter reset, and a configuration strobe control the readout. Each lane has its own output-enable, which stands in for a tri-state pin.

In a cascade, the controller drives its chained enable output low once the last item of the selected range has been consumed. At the same moment it releases its own data lanes, so the next device in the chain can take over. A BUSY input from the FPGA can stall byte-wide readout of an uncompressed image. In every other case BUSY is ignored.

Top module: `cfg_rom_reader`

## Requirements
- R1: All lane enables in `data_oe_o` are high only while `ce_ni` is 0, `oe_i` is 1, `prog_i` is 0, `cf_i` has been 1 in both the current and the previous cycle, and the end of data has not been reached. In parallel mode all 8 lanes are enabled; in serial mode only lane 0 is. A lane that is not enabled shows 0.
- R2: Word a of the ROM is (a*29+5) mod 256. In parallel mode `data_o` shows the word at the current address, and each rising clock edge with output enabled moves to the next address.
- R3: In serial mode, `data_o[0]` shows the bits of the current word most significant bit first. One bit is consumed per enabled clock, so 8 clocks consume one word.
- R4: A clock edge with `ce_ni` high or `oe_i` low resets the readout to the start address, with bit 0 of the word, and clears the end-of-data state. One such clock is enough.
- R5: With `rev_en_i` low, readout starts at address 0 and ends at address NUM_REV*REV_WORDS-1.
- R6: With `rev_en_i` high, revision r starts at r*REV_WORDS and ends at r*REV_WORDS+REV_WORDS-1. With `ext_sel_en_i` high, `rev_sel_i` is captured on every reset clock and on a rising `cf_i` while `ce_ni` is low. With `ext_sel_en_i` low, revision 0 is used.
- R7: While `prog_i` is high all lanes are disabled, and the readout position does not move.
- R8: In parallel mode with `packed_i` low, `busy_i` high holds the current word and does not advance. In serial mode, or with `packed_i` high, `busy_i` has no effect.
- R9: The clock edge that consumes the last item of the range ends the readout. From then on all lanes are disabled, the position stays put, and `ceo_no` is low whenever `ce_ni` is low and `oe_i` is high. `ceo_no` is high at all other times.
- R10: A rising edge of `cf_i` while `ce_ni` is low restarts readout at the start of the selected revision. The first item appears on the second cycle that `cf_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_i | input | 1 | Output enable; low resets the readout |
| cf_i | input | 1 | Configuration strobe; a rising edge restarts the readout |
| busy_i | input | 1 | Stall request from the FPGA |
| rev_sel_i | input | $clog2(NUM_REV) | Requested revision |
| ext_sel_en_i | input | 1 | Enables use of rev_sel_i |
| rev_en_i | input | 1 | Revision banking on or off |
| par_mode_i | input | 1 | 1 = byte-wide output, 0 = serial output |
| packed_i | input | 1 | Image is compressed; BUSY is ignored |
| prog_i | input | 1 | Programming mode; outputs released |
| data_o | output | 8 | Data lanes |
| data_oe_o | output | 8 | Per-lane output enable |
| ceo_no | output | 1 | Chained enable to the next device, active low |

## Verification
Assertions check five rules on every clock:
- lanes are never driven outside the enable conditions, and never while programming;
- the serial lane layout holds;
- a stalled byte stays stable;
- the chained enable only falls while this device is selected and its lanes are released;
- a deselect clock always returns the chained enable high.

Only the bench's scenarios can show the rest:
- the data values themselves;
- the start and end addresses of each revision;
- whether a reset was honoured after a single clock;
- when a revision is captured;
- that BUSY is ignored in serial and compressed readout;
- the exact clock on which the chained enable falls.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_IW = $clog2(BYTE_W);

  // Fixed image pattern: word a = a*29+5 mod 256
  function automatic logic [BYTE_W-1:0] rom_byte(input int unsigned a);
    int unsigned v;
    v = a * 29 + 5;
    return BYTE_W'(v);
  endfunction
endpackage

// File: rtl/cfg_rev_sel.sv
module cfg_rev_sel #(
  parameter int unsigned NUM_REV = 4,
  localparam int unsigned RVW = $clog2(NUM_REV)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ext_en_i,
  input  logic           load_i,
  input  logic [RVW-1:0] sel_i,
  output logic [RVW-1:0] rev_o,
  output logic [RVW-1:0] rev_nxt_o
);
  logic [RVW-1:0] rev_q;

  always_comb begin
    if (!ext_en_i)   rev_nxt_o = '0;
    else if (load_i) rev_nxt_o = sel_i;
    else             rev_nxt_o = rev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rev_q <= '0;
    else         rev_q <= rev_nxt_o;
  end

  assign rev_o = rev_q;
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
  import cfg_rom_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic              par_i,
  input  logic [AW-1:0]     start_i,
  input  logic [AW-1:0]     last_i,
  output logic [AW-1:0]     addr_o,
  output logic [BIT_IW-1:0] bit_o,
  output logic              done_o
);
  logic [AW-1:0]     addr_q;
  logic [BIT_IW-1:0] bit_q;
  logic              done_q;
  logic              word_end;

  assign word_end = par_i || (bit_q == BIT_IW'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      addr_q <= start_i;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (adv_i && !done_q) begin
      if (word_end) begin
        bit_q <= '0;
        if (addr_q == last_i) done_q <= 1'b1;
        else                  addr_q <= addr_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_rom_array.sv
module cfg_rom_array
  import cfg_rom_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0]     addr_i,
  output logic [BYTE_W-1:0] word_o
);
  assign word_o = rom_byte(32'(addr_i));
endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader
  import cfg_rom_pkg::*;
#(
  parameter int unsigned NUM_REV   = 4,
  parameter int unsigned REV_WORDS = 6,
  localparam int unsigned RVW = $clog2(NUM_REV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_i,
  input  logic              cf_i,
  input  logic              busy_i,
  input  logic [RVW-1:0]    rev_sel_i,
  input  logic              ext_sel_en_i,
  input  logic              rev_en_i,
  input  logic              par_mode_i,
  input  logic              packed_i,
  input  logic              prog_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] data_oe_o,
  output logic              ceo_no
);
  localparam int unsigned DEPTH = NUM_REV * REV_WORDS;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic              cf_q, cf_rise, clr, out_en, adv, stall;
  logic [RVW-1:0]    rev_q, rev_nxt;
  logic [AW-1:0]     start_addr, last_addr, addr;
  logic [BIT_IW-1:0] bit_idx;
  logic              done;
  logic [BYTE_W-1:0] word;
  logic              ser_bit;

  function automatic logic [AW-1:0] rev_base(input logic [RVW-1:0] r);
    return AW'(int'(r) * REV_WORDS);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cf_q <= 1'b0;
    else         cf_q <= cf_i;
  end

  assign cf_rise = cf_i && !cf_q;
  assign clr     = ce_ni || !oe_i || cf_rise;

  cfg_rev_sel #(.NUM_REV(NUM_REV)) u_rev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_en_i  (ext_sel_en_i),
    .load_i    (clr),
    .sel_i     (rev_sel_i),
    .rev_o     (rev_q),
    .rev_nxt_o (rev_nxt)
  );

  assign start_addr = rev_en_i ? rev_base(rev_nxt) : '0;
  assign last_addr  = rev_en_i ? rev_base(rev_q) + AW'(REV_WORDS - 1)
                               : AW'(DEPTH - 1);

  // CF must be high on two consecutive cycles so a restart never shows stale data
  assign out_en = !ce_ni && oe_i && cf_i && cf_q && !prog_i && !done;
  assign stall  = busy_i && par_mode_i && !packed_i;
  assign adv    = out_en && !stall;

  cfg_addr_ctr #(.AW(AW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (adv),
    .par_i   (par_mode_i),
    .start_i (start_addr),
    .last_i  (last_addr),
    .addr_o  (addr),
    .bit_o   (bit_idx),
    .done_o  (done)
  );

  cfg_rom_array #(.AW(AW)) u_rom (
    .addr_i (addr),
    .word_o (word)
  );

  assign ser_bit = word[~bit_idx];

  for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
    if (g == 0) begin : g_d0
      assign data_o[g]    = out_en && (par_mode_i ? word[g] : ser_bit);
      assign data_oe_o[g] = out_en;
    end else begin : g_dn
      assign data_o[g]    = out_en && par_mode_i && word[g];
      assign data_oe_o[g] = out_en && par_mode_i;
    end
  end

  assign ceo_no = !(!ce_ni && oe_i && done);
endmodule

// File: rtl/cfg_rom_reader_chk.sv
module cfg_rom_reader_chk
  import cfg_rom_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_i,
  input logic              cf_i,
  input logic              prog_i,
  input logic              busy_i,
  input logic              par_mode_i,
  input logic              packed_i,
  input logic [BYTE_W-1:0] data_o,
  input logic [BYTE_W-1:0] data_oe_o,
  input logic              ceo_no
);
  p_drive_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0) |-> (!ce_ni && oe_i && cf_i));

  p_serial_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0 && !par_mode_i) |-> (data_oe_o == 8'h01 && data_o[7:1] == '0));

  p_prog_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |-> (data_oe_o == '0 && data_o == '0));

  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && !packed_i && busy_i && data_oe_o != '0)
      |=> (data_oe_o == '0 || $stable(data_o) || !$stable(par_mode_i)));

  p_ceo_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> (!ce_ni && oe_i && data_oe_o == '0));

  p_deselect_ceo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> ceo_no);
endmodule

bind cfg_rom_reader cfg_rom_reader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_i       (oe_i),
  .cf_i       (cf_i),
  .prog_i     (prog_i),
  .busy_i     (busy_i),
  .par_mode_i (par_mode_i),
  .packed_i   (packed_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .ceo_no     (ceo_no)
);

// File: tb/tb_cfg_rom_reader.sv
module tb_cfg_rom_reader;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NREV  = 4;
  localparam int unsigned RWRDS = 6;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ce_ni = 1'b1, oe_i = 1'b1, cf_i = 1'b1, busy_i = 1'b0;
  logic [1:0] rev_sel_i = '0;
  logic       ext_sel_en_i = 1'b1, rev_en_i = 1'b1, par_mode_i = 1'b1;
  logic       packed_i = 1'b0, prog_i = 1'b0;
  logic [7:0] data_o, data_oe_o;
  logic       ceo_no;

  int checks = 0, errors = 0;
  bit finished = 0;

  cfg_rom_reader #(.NUM_REV(NREV), .REV_WORDS(RWRDS)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] w(input int a);
    return 8'((a * 29 + 5) % 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic exp_word(input int a, input string req);
    #1;
    chk(req, data_oe_o, 8'hFF);
    chk(req, data_o, w(a));
    chk(req, ceo_no, 1);
  endtask

  task automatic exp_off(input string req, input bit ceo_exp);
    #1;
    chk(req, data_oe_o, 0);
    chk(req, data_o, 0);
    chk(req, ceo_no, ceo_exp);
  endtask

  // deselect for one clock with the requested revision, then select
  task automatic start_read(input bit par, input int rev);
    ce_ni = 1'b1; oe_i = 1'b1; cf_i = 1'b1;
    par_mode_i = par; rev_sel_i = 2'(rev);
    tick();
    ce_ni = 1'b0;
  endtask

  task automatic run_read(input bit par, input int start, input int n,
                          input bit busy_pat, input bit honoured, input string req);
    int items = par ? n : n * 8;
    int idx = 0;
    int cyc = 0;
    while (idx < items) begin
      bit b = busy_pat && (cyc % 3 == 1);
      busy_i = b;
      #1;
      if (par) begin
        chk(req, data_oe_o, 8'hFF);
        chk(req, data_o, w(start + idx));
      end else begin
        chk(req, data_oe_o, 8'h01);
        chk(req, data_o, 32'((w(start + idx / 8) >> (7 - idx % 8)) & 1));
      end
      chk(req, ceo_no, 1);
      tick();
      if (!(b && honoured)) idx++;
      cyc++;
    end
    busy_i = 1'b0;
    exp_off({req, " R9 end"}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    exp_off("R1 reset", 1);

    start_read(1, 2);
    run_read(1, 2 * RWRDS, RWRDS, 0, 1, "R2 R6 rev2 par");
    // R9: position holds, ceo stays low
    for (int i = 0; i < 3; i++) begin tick(); exp_off("R9 hold", 0); end

    start_read(0, 1);
    run_read(0, RWRDS, RWRDS, 0, 0, "R3 rev1 serial");

    start_read(1, 0);
    run_read(1, 0, RWRDS, 1, 1, "R8 busy stall");

    start_read(0, 3);
    run_read(0, 3 * RWRDS, RWRDS, 1, 0, "R8 busy ignored serial");

    packed_i = 1'b1;
    start_read(1, 3);
    run_read(1, 3 * RWRDS, RWRDS, 1, 0, "R8 busy ignored packed");
    packed_i = 1'b0;

    rev_en_i = 1'b0;
    start_read(1, 3);
    run_read(1, 0, NREV * RWRDS, 0, 1, "R5 no banking");
    rev_en_i = 1'b1;

    ext_sel_en_i = 1'b0;
    start_read(1, 3);
    run_read(1, 0, RWRDS, 0, 1, "R6 ext off");
    ext_sel_en_i = 1'b1;

    // R4: one-clock reset via oe_i, then via ce_ni
    start_read(1, 1);
    exp_word(6, "R4"); tick();
    exp_word(7, "R4"); tick();
    oe_i = 1'b0; exp_off("R4 oe low", 1); tick();
    oe_i = 1'b1; exp_word(6, "R4 oe restart"); tick();
    exp_word(7, "R4"); tick();
    ce_ni = 1'b1; exp_off("R4 ce high", 1); tick();
    ce_ni = 1'b0; exp_word(6, "R4 ce restart"); tick();

    // R7: programming freezes and floats
    prog_i = 1'b1; exp_off("R7 prog", 1); tick();
    exp_off("R7 prog", 1); tick();
    prog_i = 1'b0; exp_word(7, "R7 resume"); tick();

    // R10: CF restart into revision 3
    cf_i = 1'b0; exp_off("R10 cf low", 1); tick();
    rev_sel_i = 2'd3; cf_i = 1'b1; exp_off("R10 cf first", 1); tick();
    run_read(1, 3 * RWRDS, RWRDS, 0, 1, "R10 rev3");

    // R6: select not captured without a reset or CF edge
    start_read(1, 2);
    rev_sel_i = 2'd0;
    run_read(1, 2 * RWRDS, RWRDS, 0, 1, "R6 no recapture");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule